// File: doc/BRIEF.md
# Write-masked half-word control register bank

This block holds a small set of 32-bit control registers on a plain memory-mapped bus. Each register stores only its lower 16 bits. On a write, the upper 16 bits of the write word act as a per-bit enable. Bit x of the addressed register changes only when bit x+16 of that same write is 1. Software can therefore set, clear or leave any subset of bits in one access, with no read-modify-write sequence.

The stored bits leave the block as control lanes for neighbouring logic. A separate offset reads back a 16-bit status word that other logic supplies. Reads are registered: the data appears in the cycle after the read strobe and then holds until the next strobe.

The reset input asserts asynchronously. Its release is synchronised to the clock inside the block.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: After reset, every control lane and the read data are zero.
- R2: A write to byte offset 4k (k = 0..6) updates bit x of register k to `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. When that mask bit is 0, bit x keeps its previous value.
- R3: The upper half of the write word is never stored. Each lane is 16 bits wide, and `bus_rdata[31:16]` is always zero.
- R4: One write can set some bits and clear others at once. For example, register value 0x0001 written with mask 0x0011 and data 0x0010 becomes 0x0010.
- R5: A read strobe at offset 4k returns register k as {16'h0, value} on `bus_rdata` in the following cycle.
- R6: A read strobe at offset 0x20 returns `status_in` as sampled at the strobe edge in `bus_rdata[15:0]`.
- R7: A write to offset 0x20, to an offset that is not a multiple of 4, or to any offset above 0x18 other than 0x20 leaves every register unchanged.
- R8: A read of any offset that is neither 4k (k = 0..6) nor 0x20 returns zero.
- R9: Register k drives `ctrl_out[16k+15:16k]`. The lane shows a written value from the clock edge that accepts the write.
- R10: `bus_rdata` holds its value in every cycle without a read strobe.
- R11: A read and a write to the same register in the same cycle return the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Registered read data |
| status_in | input | 16 | Status word readable at offset 0x20 |
| ctrl_out | output | 112 | Stored register bits, 16 per register, register k at [16k+15:16k] |

## Verification
The bench targets writes whose mask mixes set, clear and untouched bits in one access. A design that stored the upper half or ignored the mask would corrupt untouched bits and show nonzero upper read data. Writes to the status offset, to unaligned offsets and to offsets just past the last register are expected to leave every lane untouched. A loose decoder would alias them onto a real register. Same-cycle read and write to one register must return the old value, and a design that bypassed the new value would fail that check. The read data must also stay frozen across idle cycles while status and registers keep changing.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned WORD_W     = 2 * HALF_W;
  localparam int unsigned DEF_NREG   = 7;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_STAT   = 32'h20;

  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/hwm_rst_sync.sv
module hwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hwm_addr_dec.sv
module hwm_addr_dec #(
  parameter int unsigned NREG   = 7,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAT   = 32'h20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   reg_hit,
  output logic              stat_hit
);
  for (genvar k = 0; k < NREG; k++) begin : g_hit
    assign reg_hit[k] = (addr == ADDR_W'(k * 4));
  end

  assign stat_hit = (addr == ADDR_W'(STAT));
endmodule

// File: rtl/hwm_mask_reg.sv
module hwm_mask_reg
  import hwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output half_t             q
);
  half_t mask;
  half_t data;
  half_t q_d;
  half_t q_r;

  assign mask = wdata[WORD_W-1:HALF_W];
  assign data = wdata[HALF_W-1:0];

  always_comb begin
    q_d = (q_r & ~mask) | (data & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/hwm_read_mux.sv
module hwm_read_mux
  import hwm_pkg::*;
#(
  parameter int unsigned NREG = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [NREG-1:0]    reg_hit,
  input  logic               stat_hit,
  input  logic [NREG*HALF_W-1:0] regs,
  input  half_t              status,
  output logic [WORD_W-1:0]  rdata
);
  half_t             sel_d;
  logic [WORD_W-1:0] rdata_d;
  logic [WORD_W-1:0] rdata_q;

  always_comb begin
    sel_d = '0;
    for (int k = 0; k < NREG; k++) begin
      if (reg_hit[k]) sel_d = sel_d | regs[k*HALF_W +: HALF_W];
    end
    if (stat_hit) sel_d = sel_d | status;
    rdata_d = {{HALF_W{1'b0}}, sel_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
  import hwm_pkg::*;
#(
  parameter int unsigned NREG   = DEF_NREG,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned STAT   = DEF_STAT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [HALF_W-1:0]        status_in,
  output logic [NREG*HALF_W-1:0]   ctrl_out
);
  localparam int unsigned LANES_W = NREG * HALF_W;

  logic               rst_sync_n;
  logic [NREG-1:0]    reg_hit;
  logic               stat_hit;
  logic [LANES_W-1:0] lanes;

  hwm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hwm_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W), .STAT(STAT)) i_dec (
    .addr     (bus_addr),
    .reg_hit  (reg_hit),
    .stat_hit (stat_hit)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic  we_k;
    half_t q_k;

    assign we_k = bus_wr & reg_hit[k];

    hwm_mask_reg i_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (we_k),
      .wdata (bus_wdata),
      .q     (q_k)
    );

    assign lanes[k*HALF_W +: HALF_W] = q_k;
  end

  hwm_read_mux #(.NREG(NREG)) i_rmux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd       (bus_rd),
    .reg_hit  (reg_hit),
    .stat_hit (stat_hit),
    .regs     (lanes),
    .status   (status_in),
    .rdata    (bus_rdata)
  );

  assign ctrl_out = lanes;
endmodule

// File: rtl/hwm_ctrl_bank_chk.sv
module hwm_ctrl_bank_chk #(
  parameter int unsigned NREG   = 7,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAT   = 32'h20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [15:0]            status_in,
  input logic [NREG*16-1:0]     ctrl_out
);
  logic mapped;
  assign mapped = ((bus_addr[1:0] == 2'b00) && (32'(bus_addr[ADDR_W-1:2]) < NREG))
                  || (bus_addr == ADDR_W'(STAT));

  for (genvar k = 0; k < NREG; k++) begin : g_lane
    // R2: masked update of the addressed lane
    assert_masked_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(k * 4)) |=>
        ctrl_out[k*16 +: 16] == (($past(ctrl_out[k*16 +: 16]) & ~$past(bus_wdata[31:16]))
                                 | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));
    // R7: a lane changes only on a write to its own offset
    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(k * 4)) |=> $stable(ctrl_out[k*16 +: 16]));
  end

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(STAT)) |=> bus_rdata[15:0] == $past(status_in));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> bus_rdata == 32'h0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind hwm_ctrl_bank hwm_ctrl_bank_chk #(.NREG(NREG), .ADDR_W(ADDR_W), .STAT(STAT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .status_in (status_in),
  .ctrl_out  (ctrl_out)
);

// File: tb/test_hwm_ctrl_bank.sv
`timescale 1ns/1ps
module test_hwm_ctrl_bank;
  localparam int NREG = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_wr, bus_rd;
  logic [7:0]       bus_addr;
  logic [31:0]      bus_wdata;
  logic [31:0]      bus_rdata;
  logic [15:0]      status_in;
  logic [NREG*16-1:0] ctrl_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [15:0] mdl [NREG];

  always #5 clk = ~clk;

  hwm_ctrl_bank i_hwm_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_in(status_in), .ctrl_out(ctrl_out)
  );

  function automatic logic [NREG*16-1:0] exp_lanes();
    logic [NREG*16-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*16 +: 16] = mdl[k];
    return v;
  endfunction

  function automatic int reg_index(logic [7:0] a);
    if (a[1:0] == 2'b00 && int'(a[7:2]) < NREG) return int'(a[7:2]);
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a, logic [15:0] st);
    int i = reg_index(a);
    if (i >= 0) return {16'h0, mdl[i]};
    if (a == 8'h20) return {16'h0, st};
    return 32'h0;
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one access cycle; inputs driven at negedge, result sampled at next negedge
  task automatic access(bit wr, bit rd, logic [7:0] a, logic [31:0] w, logic [15:0] st,
                        string req);
    logic [31:0] er;
    int i;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = w; status_in = st;
    er = exp_read(a, st);
    i  = reg_index(a);
    if (wr && i >= 0) mdl[i] = merge(mdl[i], w);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    status_in = 16'(~st);
    if (rd) check(bus_rdata == er, req, bus_rdata, er);
    if (wr) check(ctrl_out == exp_lanes(), req, ctrl_out, exp_lanes());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < NREG; k++) mdl[k] = 16'h0;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; status_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(ctrl_out == '0, "R1 lanes", ctrl_out, 0);
    check(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 0);
    for (int k = 0; k < NREG; k++) access(0, 1, 8'(k*4), 0, 16'h0, "R1 R5 read");

    // R2 R9: full mask write, then partial mask keeps others
    access(1, 0, 8'h00, 32'hFFFF_A5A5, 16'h0, "R2 R9 full");
    access(1, 0, 8'h00, 32'h00F0_0000, 16'h0, "R2 partial");
    access(1, 0, 8'h18, 32'h8001_FFFF, 16'h0, "R2 R9 last");
    // R4: set and clear in one write
    access(1, 0, 8'h04, 32'hFFFF_0001, 16'h0, "R4 prep");
    access(1, 0, 8'h04, 32'h0011_0010, 16'h0, "R4 set-clear");
    check(ctrl_out[31:16] == 16'h0010, "R4 value", ctrl_out[31:16], 16'h0010);
    // R3: upper half not stored
    access(0, 1, 8'h00, 0, 16'h0, "R3 R5 readback");
    check(bus_rdata[31:16] == 16'h0, "R3 upper", bus_rdata, 0);
    // R7: ignored writes
    access(1, 0, 8'h20, 32'hFFFF_FFFF, 16'h0, "R7 status wr");
    access(1, 0, 8'h1C, 32'hFFFF_FFFF, 16'h0, "R7 past end");
    access(1, 0, 8'h01, 32'hFFFF_FFFF, 16'h0, "R7 unaligned");
    access(1, 0, 8'h24, 32'hFFFF_FFFF, 16'h0, "R7 beyond status");
    // R6 R8
    access(0, 1, 8'h20, 0, 16'hBEEF, "R6 status");
    access(0, 1, 8'h1C, 0, 16'h1234, "R8 unmapped");
    access(0, 1, 8'hFE, 0, 16'h1234, "R8 unmapped hi");
    // R11: same-cycle read and write returns old value
    access(1, 1, 8'h08, 32'hFFFF_C3C3, 16'h0, "R11 rw same");
    access(0, 1, 8'h08, 0, 16'h0, "R11 new value");
    // R10: hold without strobe
    access(0, 1, 8'h20, 0, 16'h7E57, "R10 prep");
    held = bus_rdata;
    access(1, 0, 8'h0C, 32'hFFFF_FFFF, 16'hAAAA, "R10 write");
    repeat (3) @(negedge clk);
    check(bus_rdata == held, "R10 hold", bus_rdata, held);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel = int'($urandom % 12);
      int op  = int'($urandom % 3);
      case (sel)
        7: a = 8'h20;
        8: a = 8'h1C;
        9: a = 8'h24;
        10: a = 8'h02 + 8'($urandom % 2);
        11: a = 8'hFC;
        default: a = 8'(sel * 4);
      endcase
      access(op != 1, op != 0, a, $urandom, 16'($urandom), "R2 R7 R8 R11 random");
    end

    done = 1;
    finish_run();
  end
endmodule